// File: doc/BRIEF.md
# Static RAM Cycle Sequencer

This block sits between a synchronous host and an asynchronous static RAM. The host raises a one-cycle request with a write flag, an address and, for writes, a data word. The block then drives the memory's address bus, its data-in bus and its three active-low strobes (chip select, output enable, write enable) through a fixed series of counted phases. When the cycle is over it raises a one-cycle done pulse. Read data is returned on a register that holds its value until the next read.

Every timing margin the memory needs is its own cycle-count parameter, each at least 1. The margins are: the address setup before the strobes, the width of the write pulse, the data hold after the write ends, the address hold after the strobes are released, and the read access time. The read access time must cover the slower of the address-to-data delay and the select-to-data delay. Address and write data are registered when the request is accepted. They stay unchanged until the next accepted request, so every setup and hold window counts from stable values.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, mem_cs_n, mem_oe_n and mem_we_n are all 1 and done is 0.
- R2: A read drives mem_addr with all three strobes high for AS_CYC cycles. It then holds mem_cs_n and mem_oe_n low together for RA_CYC cycles while mem_we_n stays high.
- R3: rd_data takes the value on mem_dout at the clock edge that ends the last read-access cycle. It keeps that value through later writes until the next read completes.
- R4: A write presents mem_addr and mem_din with all strobes high for AS_CYC cycles before mem_cs_n and mem_we_n fall together. The address and data do not change in the cycle in which chip select falls.
- R5: During a write, mem_cs_n and mem_we_n are low for exactly WP_CYC cycles and mem_oe_n stays high.
- R6: After a write pulse ends, mem_din and mem_addr stay unchanged for DH_CYC cycles. The address then stays unchanged for AH_CYC more cycles, with all strobes high.
- R7: After a read ends, mem_addr stays unchanged for AH_CYC cycles with all strobes high.
- R8: done is high for exactly one cycle. It rises AS_CYC+RA_CYC+AH_CYC clock edges after the edge that accepts a read, and AS_CYC+WP_CYC+DH_CYC+AH_CYC edges after the edge that accepts a write.
- R9: A request is accepted only while the sequencer is idle, including the cycle in which done is high. A request raised while a cycle is in progress starts no bus cycle and changes no memory word.
- R10: mem_oe_n and mem_we_n are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Host address |
| req_wdata | input | DW | Host write data |
| rd_data | output | DW | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Memory address bus |
| mem_din | output | DW | Memory data-in bus |
| mem_dout | input | DW | Memory data-out bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The bench's memory model returns a garbage word until output enable has been low for the full access time. A design that captured read data one cycle early would therefore return that garbage instead of the stored word. Back-to-back transactions start in the done cycle, so a sequencer that needed an extra idle cycle, or that ended a phase one count off, shows up as a wrong latency or a strobe edge in the wrong cycle. A request injected mid-cycle targets an address that is read back later. A sequencer that accepted it while busy would corrupt that word or emit a second done. The address and data buses are checked for stability across every setup, pulse and hold cycle, which catches register reloads during a cycle.

// File: rtl/sram_seq_pkg.sv
// Shared types and helpers for the static RAM cycle sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sram_seq_pkg;

    // Sequencer phases, one per counted timing margin.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_DHOLD  = 3'd3,
        ST_AHOLD  = 3'd4
    } seq_state_e;

    // Larger of two integers, used to size the phase counter.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Loadable down counter that times one sequencer phase.
// A phase of N cycles is started by loading N-1; last is high in its final cycle.
// Assumes the loaded value fits in CW bits.
module sram_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Count down toward zero; a load restarts the phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: walks idle, setup, active, data hold and address hold.
// The strobes are registered from the next state so that they change
// glitch-free on the same edge as the phase. Assumes every *_CYC >= 1.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int AS_CYC = 2,
    parameter int WP_CYC = 3,
    parameter int DH_CYC = 1,
    parameter int AH_CYC = 2,
    parameter int RA_CYC = 3,
    parameter int CW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          capture,
    output logic          done,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n
);

    localparam logic [CW-1:0] AS_M1 = CW'(AS_CYC - 1);
    localparam logic [CW-1:0] WP_M1 = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] DH_M1 = CW'(DH_CYC - 1);
    localparam logic [CW-1:0] AH_M1 = CW'(AH_CYC - 1);
    localparam logic [CW-1:0] RA_M1 = CW'(RA_CYC - 1);

    seq_state_e state_q, state_d;
    logic       wr_q;
    logic       finish;

    // Next phase, timer reload value and single-cycle strobes.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = AS_M1;
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_ACTIVE;
                    tmr_load = 1'b1;
                    tmr_val  = wr_q ? WP_M1 : RA_M1;
                end
            end
            ST_ACTIVE: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (wr_q) begin
                        state_d = ST_DHOLD;
                        tmr_val = DH_M1;
                    end else begin
                        capture = 1'b1;
                        state_d = ST_AHOLD;
                        tmr_val = AH_M1;
                    end
                end
            end
            ST_DHOLD: begin
                if (tmr_last) begin
                    state_d  = ST_AHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = AH_M1;
                end
            end
            ST_AHOLD: begin
                if (tmr_last) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register and latched transfer direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)
                wr_q <= req_write;
        end
    end

    // Registered strobes and done pulse, all inactive during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            oe_n <= 1'b1;
            we_n <= 1'b1;
            done <= 1'b0;
        end else begin
            cs_n <= !(state_d == ST_ACTIVE);
            oe_n <= !((state_d == ST_ACTIVE) && !wr_q);
            we_n <= !((state_d == ST_ACTIVE) && wr_q);
            done <= finish;
        end
    end

endmodule

// File: rtl/sram_seq_datapath.sv
// Address, write-data and read-capture registers.
// Address and write data load only when a request is accepted, so they stay
// stable for the whole bus cycle and its hold phases.
module sram_seq_datapath #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dout,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_din,
    output logic [DW-1:0] rd_data
);

    // Hold the request's address and data for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_din  <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_din  <= req_wdata;
        end
    end

    // Capture memory output at the end of the read access phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (capture)
            rd_data <= mem_dout;
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
// Top of the static RAM cycle sequencer. Turns single-cycle host requests
// into counted read and write bus cycles for an asynchronous static RAM.
// Assumes separate data-in and data-out memory buses and every *_CYC >= 1.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int AS_CYC = 2,
    parameter int WP_CYC = 3,
    parameter int DH_CYC = 1,
    parameter int AH_CYC = 2,
    parameter int RA_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_din,
    input  logic [DW-1:0] mem_dout,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n
);

    localparam int MAXLEN = max2(max2(max2(AS_CYC, WP_CYC), max2(DH_CYC, AH_CYC)), RA_CYC);
    localparam int CW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          accept;
    logic          capture;

    sram_seq_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_seq_fsm #(
        .AS_CYC (AS_CYC),
        .WP_CYC (WP_CYC),
        .DH_CYC (DH_CYC),
        .AH_CYC (AH_CYC),
        .RA_CYC (RA_CYC),
        .CW     (CW)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .done      (done),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n)
    );

    sram_seq_datapath #(.AW(AW), .DW(DW)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dout  (mem_dout),
        .mem_addr  (mem_addr),
        .mem_din   (mem_din),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
// Protocol checker for the static RAM cycle sequencer, bound to the top.
// Watches only the top's ports; the write pulse width is counted here.
module sram_seq_ctrl_chk #(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int WP_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_din,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n
);

    logic [15:0] wlow_q;

    // Number of consecutive cycles write enable has been low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wlow_q <= '0;
        else if (mem_we_n)
            wlow_q <= '0;
        else if (wlow_q != 16'hFFFF)
            wlow_q <= wlow_q + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_cs_n && mem_oe_n && mem_we_n && !done));

    p_oe_we_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_we_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wlow_q >= 16'(WP_CYC)));

    p_setup_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> ($stable(mem_addr) && $stable(mem_din)));

    p_active_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$fell(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

    p_release_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |=> $stable(mem_addr));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_cs_n && $past(mem_cs_n)));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .AW     (AW),
    .DW     (DW),
    .WP_CYC (WP_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .mem_addr (mem_addr),
    .mem_din  (mem_din),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n)
);

// File: tb/sram_seq_ctrl_tb_top.sv
// Bench for the static RAM cycle sequencer: an asynchronous memory model,
// directed corner cases and seeded random traffic against a shadow array.
module sram_seq_ctrl_tb_top;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int AS = 2;
    localparam int WP = 3;
    localparam int DH = 1;
    localparam int AH = 2;
    localparam int RA = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_din;
    logic [DW-1:0] mem_dout;
    logic          mem_cs_n, mem_oe_n, mem_we_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [DW-1:0] sram   [256];
    logic [DW-1:0] shadow [256];
    logic [DW-1:0] last_rd = '0;
    int            oe_cnt = 0;
    logic          we_low_prev = 1'b0;

    always #5 clk = ~clk;

    sram_seq_ctrl #(
        .AW(AW), .DW(DW), .AS_CYC(AS), .WP_CYC(WP),
        .DH_CYC(DH), .AH_CYC(AH), .RA_CYC(RA)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .done(done), .mem_addr(mem_addr), .mem_din(mem_din),
        .mem_dout(mem_dout), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    // Memory model: output is garbage until the access time has elapsed.
    always @(posedge clk) begin
        if (!mem_cs_n && !mem_oe_n) oe_cnt <= oe_cnt + 1;
        else                        oe_cnt <= 0;
    end
    assign mem_dout = (!mem_cs_n && !mem_oe_n)
                    ? ((oe_cnt >= RA - 1) ? sram[mem_addr] : 16'hDEAD) : 16'h0000;

    // Memory model: a write is stored when write enable is released.
    always @(negedge clk) begin
        if (we_low_prev && mem_we_n) sram[mem_addr] = mem_din;
        we_low_prev = !mem_we_n;
    end

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(a * 16'h0101 + 16'h1234);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One host transaction, started at a negedge; returns at the done negedge.
    task automatic xact(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit inject);
        int  len   = wr ? (AS + WP + DH + AH) : (AS + RA + AH);
        int  plen  = wr ? WP : RA;
        int  n     = 0;
        int  bad_ctl = 0;
        int  bad_bus = 0;
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        while (!done && n <= len + 4) begin
            bit act = (n >= AS) && (n < AS + plen);
            if (mem_cs_n != !act) bad_ctl++;
            if (mem_oe_n != !(act && !wr)) bad_ctl++;
            if (mem_we_n != !(act && wr)) bad_ctl++;
            if (mem_addr != a) bad_bus++;
            if (wr && mem_din != d) bad_bus++;
            if (inject && n == 1) begin
                req = 1'b1; req_write = 1'b1; req_addr = a ^ 8'h80; req_wdata = 16'hBAD1;
            end else begin
                req = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        req = 1'b0;
        if (wr) begin
            check(bad_ctl == 0, "R4 R5 R10 write strobes", bad_ctl, 0);
            check(bad_bus == 0, "R4 R6 write address/data hold", bad_bus, 0);
            check(n == len, "R8 write latency", n, len);
            shadow[a] = d;
            check(rd_data == last_rd, "R3 rd_data held over write", rd_data, last_rd);
        end else begin
            check(bad_ctl == 0, "R2 R10 read strobes", bad_ctl, 0);
            check(bad_bus == 0, "R2 R7 read address hold", bad_bus, 0);
            check(n == len, "R8 read latency", n, len);
            check(rd_data == shadow[a], "R3 read data", rd_data, shadow[a]);
            last_rd = shadow[a];
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            sram[i]   = init_word(i);
            shadow[i] = init_word(i);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: strobes inactive and done low while in reset.
        check(mem_cs_n && mem_oe_n && mem_we_n && !done, "R1 reset outputs",
              {mem_cs_n, mem_oe_n, mem_we_n, done}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !done, "R1 first cycle after reset",
              {mem_cs_n, mem_oe_n, mem_we_n, done}, 4'b1110);

        // Directed: read before any write, corner addresses, back-to-back.
        xact(1'b0, 8'h00, '0, 1'b0);
        xact(1'b1, 8'hFF, 16'hA5C3, 1'b0);
        xact(1'b0, 8'hFF, '0, 1'b0);
        xact(1'b1, 8'h00, 16'h0000, 1'b0);
        xact(1'b1, 8'h00, 16'hFFFF, 1'b0);
        xact(1'b0, 8'h00, '0, 1'b0);

        // R9: request raised mid-cycle must be ignored.
        xact(1'b1, 8'h05, 16'h7777, 1'b1);
        repeat (4) begin
            @(negedge clk);
            check(!done && mem_cs_n, "R9 no cycle from busy request",
                  {done, mem_cs_n}, 2'b01);
        end
        xact(1'b0, 8'h85, '0, 1'b0);
        check(rd_data == init_word(8'h85), "R9 busy request wrote nothing",
              rd_data, init_word(8'h85));
        xact(1'b0, 8'h05, '0, 1'b1);

        // Random mix of reads and writes over a small address window.
        for (int k = 0; k < 40; k++) begin
            bit            w = $urandom() % 2;
            logic [AW-1:0] a = AW'($urandom() % 16);
            logic [DW-1:0] d = DW'($urandom());
            xact(w, a, d, 1'b0);
            if (($urandom() % 4) == 0) repeat ($urandom() % 3 + 1) @(negedge clk);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule